// File: doc/BRIEF.md
# Rate-Gated Multirate CIC Decimator

This block is a single-channel cascaded integrator-comb decimator with four integrators and four combs, differential delay one. The decimation ratio is picked at run time from four choices: 5, 10, 20 or 50. The sample stream is 12-bit two's complement and comes in with a valid strobe. The block emits a 16-bit two's-complement result with a one-cycle valid pulse. The output is scaled by a per-rate right shift so that a full-scale input stays close to full scale at the output.

The datapath is sized for the widest rate, which is 36 bits in 4-bit slices. Slices above the width a rate needs are held frozen. Their adder operands are forced to zero and the carry from the slice below them is blocked. The arithmetic is modular, so the kept output bits stay exact. The four comb stages share one adder/subtractor. A decimated sample is stepped through them over four clock cycles, which fit inside the at-least-five-cycle gap between decimated samples.

A change on the rate input restarts the filter. In that cycle all filter state and the decimation phase are cleared, and the new gating takes effect in the next cycle.

Top module: `cic_decim_gated`

## Requirements
- R1: `rate_sel` encodes the decimation ratio as 0→5, 1→10, 2→20, 3→50. Exactly one result is produced for every R accepted samples, counted from the last clear.
- R2: Each result equals the full-precision output of a 4-stage CIC with pipelined integrators, arithmetically shifted right and truncated to its low 16 bits. Each integrator adds the previous-cycle value of the stage before it, and the decimated value is the last integrator's new value. The shift is 6, 10, 14 or 19 for `rate_sel` 0, 1, 2 or 3.
- R3: A constant input x settles to floor(x·R⁴ / 2^shift). For example, 2047 at ratio 50 gives 24402 and −2048 gives −24415.
- R4: `in_data` has no effect on any result while `in_valid` is low.
- R5: In a cycle where `rate_sel` differs from the ratio in use, all integrator, comb and phase state is cleared. A sample presented in that cycle is dropped, and a partially collected decimation period is discarded.
- R6: `out_valid` is high for one cycle per result and is never high in two consecutive cycles.
- R7: Slices above the width needed for the current ratio keep their stored values unchanged. The gating never alters a result compared with an ungated full-width filter.
- R8: The comb section accepts a new decimated sample only when idle. `out_valid` rises on the fifth clock edge after the edge that accepts the sample completing a decimation period.
- R9: After reset, `out_valid` is low and `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_sel | input | 2 | Decimation ratio code (0:5, 1:10, 2:20, 3:50) |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 12 | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Signed scaled result |

## Verification
The assertions assume that `rate_sel` holds steady apart from deliberate changes. They also assume `in_valid` is high at most once per cycle, so a decimated sample arrives no more often than every fifth cycle and the comb scheduler is always idle when one comes. The stimulus changes the ratio only from idle stretches, except in one directed test that switches during a live stream to exercise the clear. Data is compared against a wide behavioural model, which is restarted in step with every ratio change. Idle cycles carry junk data so that the ignore rule is exercised.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int N_RATES = 4;
  localparam int RATE_SEL_W = 2;
  localparam int RATE_TAB [N_RATES] = '{5, 10, 20, 50};

  // bits of growth: smallest b with 2^b >= rate^stages
  function automatic int gain_bits(input int rate, input int stages);
    longint p;
    int b;
    p = 1;
    for (int n = 0; n < stages; n++) p = p * longint'(rate);
    b = 0;
    for (int i = 0; i < 62; i++) if ((longint'(1) <<< b) < p) b++;
    return b;
  endfunction

  function automatic int max_rate();
    int m;
    m = 0;
    for (int r = 0; r < N_RATES; r++) if (RATE_TAB[r] > m) m = RATE_TAB[r];
    return m;
  endfunction
endpackage

// File: rtl/cic_slice_addsub.sv
module cic_slice_addsub #(
  parameter int SW  = 4,
  parameter int NSL = 9,
  localparam int W  = SW * NSL
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sub,
  input  logic [NSL-1:0] act,
  output logic [W-1:0]   s
);
  logic [NSL-1:0] cy;
  assign cy[0] = sub;

  for (genvar k = 0; k < NSL; k++) begin : g_sl
    logic [SW-1:0] ag, bg;
    logic          ci;
    // operand isolation: a frozen slice sees zeros and no carry
    assign ag = act[k] ? a[k*SW +: SW] : '0;
    assign bg = act[k] ? (sub ? ~b[k*SW +: SW] : b[k*SW +: SW]) : '0;
    assign ci = cy[k] & act[k];
    if (k == NSL - 1) begin : g_top
      assign s[k*SW +: SW] = ag + bg + {{(SW-1){1'b0}}, ci};
    end else begin : g_mid
      assign {cy[k+1], s[k*SW +: SW]} = {1'b0, ag} + {1'b0, bg} + {{SW{1'b0}}, ci};
    end
  end
endmodule

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int IN_W   = 12,
  parameter int STAGES = 4,
  parameter int SW     = 4,
  parameter int NSL    = 9,
  parameter int CNT_W  = 6,
  localparam int W     = SW * NSL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [NSL-1:0]    act,
  input  logic [CNT_W-1:0]  lim,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_data,
  output logic              dec_valid,
  output logic [W-1:0]      dec_data
);
  logic [W-1:0]     acc_q [STAGES];
  logic [W-1:0]     acc_d [STAGES];
  logic [W-1:0]     acc_n [STAGES];
  logic [W-1:0]     opnd  [STAGES];
  logic [NSL-1:0]   sl_en;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      assign opnd[s] = {{(W-IN_W){in_data[IN_W-1]}}, in_data};
    end else begin : g_next
      assign opnd[s] = acc_q[s-1];
    end
    cic_slice_addsub #(.SW(SW), .NSL(NSL)) u_add (
      .a(acc_q[s]), .b(opnd[s]), .sub(1'b0), .act(act), .s(acc_d[s]));
  end

  always_comb begin
    for (int k = 0; k < NSL; k++) sl_en[k] = clr | (in_valid & act[k]);
    for (int s = 0; s < STAGES; s++) acc_n[s] = clr ? '0 : acc_d[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) acc_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++)
        for (int k = 0; k < NSL; k++)
          if (sl_en[k]) acc_q[s][k*SW +: SW] <= acc_n[s][k*SW +: SW];
    end
  end

  assign dec_valid = in_valid & ~clr & (cnt_q == lim);
  assign dec_data  = acc_d[STAGES-1];

  always_comb begin
    cnt_n = cnt_q;
    if (clr)            cnt_n = '0;
    else if (dec_valid) cnt_n = '0;
    else if (in_valid)  cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_chk_s
    for (genvar k = 0; k < NSL; k++) begin : g_chk_k
      // R7
      gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act[k] && !clr) |=> $stable(acc_q[s][k*SW +: SW]));
    end
  end

  // R5
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && acc_q[STAGES-1] == '0 && acc_q[0] == '0));

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);
endmodule

// File: rtl/cic_comb_seq.sv
module cic_comb_seq #(
  parameter int STAGES = 4,
  parameter int SW     = 4,
  parameter int NSL    = 9,
  localparam int W     = SW * NSL,
  localparam int STP_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [NSL-1:0] act,
  input  logic           dec_valid,
  input  logic [W-1:0]   dec_data,
  output logic           res_valid,
  output logic [W-1:0]   res_data
);
  logic [W-1:0]     cur_q, cur_n, diff;
  logic [W-1:0]     dly_q [STAGES];
  logic [W-1:0]     dly_n [STAGES];
  logic             busy_q, busy_n, done_q, done_n;
  logic [STP_W-1:0] stp_q, stp_n;

  // the single shared subtractor for every comb stage
  cic_slice_addsub #(.SW(SW), .NSL(NSL)) u_sub (
    .a(cur_q), .b(dly_q[stp_q]), .sub(1'b1), .act(act), .s(diff));

  always_comb begin
    cur_n  = cur_q;
    busy_n = busy_q;
    stp_n  = stp_q;
    done_n = 1'b0;
    for (int k = 0; k < STAGES; k++) dly_n[k] = dly_q[k];
    if (clr) begin
      cur_n  = '0;
      busy_n = 1'b0;
      stp_n  = '0;
      for (int k = 0; k < STAGES; k++) dly_n[k] = '0;
    end else if (dec_valid) begin
      cur_n  = dec_data;
      busy_n = 1'b1;
      stp_n  = '0;
    end else if (busy_q) begin
      dly_n[stp_q] = cur_q;
      cur_n        = diff;
      if (stp_q == STP_W'(STAGES - 1)) begin
        stp_n  = '0;
        busy_n = 1'b0;
        done_n = 1'b1;
      end else begin
        stp_n = stp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      busy_q <= 1'b0;
      stp_q  <= '0;
      done_q <= 1'b0;
      for (int k = 0; k < STAGES; k++) dly_q[k] <= '0;
    end else begin
      cur_q  <= cur_n;
      busy_q <= busy_n;
      stp_q  <= stp_n;
      done_q <= done_n;
      for (int k = 0; k < STAGES; k++) dly_q[k] <= dly_n[k];
    end
  end

  assign res_valid = done_q;
  assign res_data  = cur_q;

  // R8
  comb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !busy_q);
endmodule

// File: rtl/cic_decim_gated.sv
module cic_decim_gated #(
  parameter int IN_W    = 12,
  parameter int OUT_W   = 16,
  parameter int STAGES  = 4,
  parameter int SLICE_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [cic_pkg::RATE_SEL_W-1:0]    rate_sel,
  input  logic                              in_valid,
  input  logic [IN_W-1:0]                   in_data,
  output logic                              out_valid,
  output logic [OUT_W-1:0]                  out_data
);
  import cic_pkg::*;

  localparam int RMAX  = max_rate();
  localparam int GROW  = gain_bits(RMAX, STAGES);
  localparam int NSL   = (IN_W + GROW + SLICE_W - 1) / SLICE_W;
  localparam int ACC_W = NSL * SLICE_W;
  localparam int CNT_W = $clog2(RMAX);
  localparam int SH_W  = $clog2(ACC_W);

  logic [NSL-1:0]   mask_tab [N_RATES];
  logic [CNT_W-1:0] lim_tab  [N_RATES];
  logic [SH_W-1:0]  sh_tab   [N_RATES];

  for (genvar r = 0; r < N_RATES; r++) begin : g_rate
    localparam int GB = gain_bits(RATE_TAB[r], STAGES);
    localparam int NS = (IN_W + GB + SLICE_W - 1) / SLICE_W;
    assign mask_tab[r] = {NSL{1'b1}} >> (NSL - NS);
    assign lim_tab[r]  = CNT_W'(RATE_TAB[r] - 1);
    assign sh_tab[r]   = SH_W'(IN_W + GB - OUT_W);
  end

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [RATE_SEL_W-1:0] rate_q;
  logic [NSL-1:0]        act_q;
  logic                  clr;
  assign clr = (rate_sel != rate_q);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rate_q <= '0;
      act_q  <= {NSL{1'b1}} >> (NSL - (IN_W + gain_bits(RATE_TAB[0], STAGES) + SLICE_W - 1) / SLICE_W);
    end else if (clr) begin
      rate_q <= rate_sel;
      act_q  <= mask_tab[rate_sel];
    end
  end

  logic             dec_valid, res_valid;
  logic [ACC_W-1:0] dec_data, res_data;

  cic_integ #(.IN_W(IN_W), .STAGES(STAGES), .SW(SLICE_W), .NSL(NSL), .CNT_W(CNT_W)) u_integ (
    .clk(clk), .rst_n(rst_q), .clr(clr), .act(act_q), .lim(lim_tab[rate_q]),
    .in_valid(in_valid), .in_data(in_data),
    .dec_valid(dec_valid), .dec_data(dec_data));

  cic_comb_seq #(.STAGES(STAGES), .SW(SLICE_W), .NSL(NSL)) u_comb (
    .clk(clk), .rst_n(rst_q), .clr(clr), .act(act_q),
    .dec_valid(dec_valid), .dec_data(dec_data),
    .res_valid(res_valid), .res_data(res_data));

  logic             ov_n;
  logic [OUT_W-1:0] od_n;
  assign ov_n = res_valid & ~clr;
  assign od_n = res_data[sh_tab[rate_q] +: OUT_W];

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= ov_n;
      if (ov_n) out_data <= od_n;
    end
  end

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |=> !out_valid);
endmodule

// File: tb/sim_cic_decim_gated.sv
module sim_cic_decim_gated;
  logic        clk;
  logic        rst_n;
  logic [1:0]  rate_sel;
  logic        in_valid;
  logic [11:0] in_data;
  logic        out_valid;
  logic [15:0] out_data;

  cic_decim_gated u0 (.clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .in_valid(in_valid),
                      .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam int RT  [4] = '{5, 10, 20, 50};
  localparam int SHT [4] = '{6, 10, 14, 19};
  localparam int NV = 9;
  localparam int VR [NV] = '{0, 0, 1, 1, 2, 2, 3, 3, 0};
  localparam int VX [NV] = '{2047, -2048, 2047, -2048, 1000, -1, 2047, -2048, 1};
  localparam int VE [NV] = '{19990, -20000, 19990, -20000, 9765, -10, 24402, -24415, 9};

  int total, bad, got_n, last_out, cur_sel;
  longint mi [4];
  longint md [4];
  int mcnt;
  int exp_q [$];
  bit done;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 4; s++) begin mi[s] = 0; md[s] = 0; end
    mcnt = 0;
  endtask

  task automatic model_push(input int x);
    longint n [4];
    longint c, d, v;
    logic signed [15:0] t;
    n[0] = mi[0] + longint'(x);
    for (int s = 1; s < 4; s++) n[s] = mi[s] + mi[s-1];
    for (int s = 0; s < 4; s++) mi[s] = n[s];
    if (mcnt == RT[cur_sel] - 1) begin
      mcnt = 0;
      c = n[3];
      for (int k = 0; k < 4; k++) begin d = c - md[k]; md[k] = c; c = d; end
      v = c >>> SHT[cur_sel];
      t = v[15:0];
      exp_q.push_back(int'(t));
    end else begin
      mcnt++;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 R7 unexpected result", int'($signed(out_data)), 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'($signed(out_data)) == e, "R2 R7 result vs model", int'($signed(out_data)), e);
      end
      last_out = int'($signed(out_data));
      got_n++;
    end
  end

  task automatic send(input int x);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 12'(x);
    model_push(x);
  endtask

  // R4: idle cycles carry junk data
  task automatic idle(input int n, input int junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 12'(junk + i * 733);
    end
  endtask

  task automatic set_rate(input int sel);
    idle(8, 0);
    @(negedge clk);
    in_valid = 1'b0;
    rate_sel = 2'(sel);
    if (sel != cur_sel) model_clear();
    cur_sel = sel;
    idle(2, 0);
  endtask

  task automatic drain();
    idle(80, 1111);
    chk(exp_q.size() == 0, "R1 missing results", exp_q.size(), 0);
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; got_n = 0; last_out = 0; cur_sel = 0;
    model_clear();
    rst_n = 1'b0; rate_sel = 2'd0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    // R9
    chk(out_valid == 1'b0, "R9 valid in reset", int'(out_valid), 0);
    chk(out_data == 16'd0, "R9 data in reset", int'(out_data), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(4, 0);
    chk(out_valid == 1'b0 && out_data == 16'd0, "R9 after release", int'(out_data), 0);

    // R3 settled gain per ratio, all results also against the model
    for (int i = 0; i < NV; i++) begin
      set_rate(VR[i]);
      for (int j = 0; j < 12 * RT[VR[i]]; j++) send(VX[i]);
      drain();
      chk(last_out == VE[i], "R3 settled value", last_out, VE[i]);
    end

    // R4 constant input with junk during gaps
    set_rate(0);
    for (int j = 0; j < 80; j++) begin
      send(500);
      idle(1, -2048);
    end
    drain();
    chk(last_out == 4882, "R4 junk on idle cycles", last_out, 4882);

    // R1 random data with gaps, every ratio, count of results
    for (int p = 3; p >= 0; p--) begin
      int sent, g0;
      set_rate(p);
      sent = 0;
      g0 = got_n;
      for (int j = 0; j < 20 * RT[p]; j++) begin
        if ($urandom_range(0, 2) == 0) idle(1, int'($urandom_range(0, 4095)));
        else begin send(int'($urandom_range(0, 4095)) - 2048); sent++; end
      end
      drain();
      chk(got_n - g0 == sent / RT[p], "R1 result count", got_n - g0, sent / RT[p]);
    end

    // R5 ratio switch in the middle of a live stream
    set_rate(3);
    for (int j = 0; j < 137; j++) send(int'($urandom_range(0, 4095)) - 2048);
    @(negedge clk);
    rate_sel = 2'd1;
    in_valid = 1'b1;
    in_data  = 12'(1234);
    model_clear();
    cur_sel = 1;
    begin
      int g0;
      g0 = got_n;
      for (int j = 0; j < 100; j++) send(int'($urandom_range(0, 4095)) - 2048);
      drain();
      chk(got_n - g0 == 10, "R5 results after switch", got_n - g0, 10);
    end

    // R8 latency and R6 single pulse
    set_rate(0);
    begin
      bit v5, v6, v7;
      for (int j = 0; j < 5; j++) send(100);
      @(posedge clk);
      #1 in_valid = 1'b0;
      for (int k = 1; k <= 7; k++) begin
        @(negedge clk);
        if (k == 5) v5 = out_valid;
        if (k == 6) v6 = out_valid;
        if (k == 7) v7 = out_valid;
      end
      chk(v5 == 1'b0, "R8 not early", int'(v5), 0);
      chk(v6 == 1'b1, "R8 on fifth edge", int'(v6), 1);
      chk(v7 == 1'b0, "R6 single cycle", int'(v7), 0);
    end
    drain();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule